// File: doc/BRIEF.md
# Pin-Change Interrupt Detector

This block watches a vector of input pins that are already synchronised to the system clock and raises a sticky status flag when any pin selected by a mask meets a programmed condition. The condition is one of four modes: any edge, rising edge, falling edge, or a held low level. A select bit chooses which of two copies of the pins is monitored: the raw samples or a debounced version of them. The debouncing is produced outside this block.

Edges are found by comparing the monitored vector with a registered copy taken one cycle earlier. No edge is reported in the first cycle after reset. No edge is reported in the cycle in which the source select changes, so switching sources never raises a false event. Software clears the flag with a one-cycle clear strobe. The interrupt request is the flag gated by an enable bit. The flag keeps tracking events while the request is disabled, so polling still works.

Register decoding and debouncing belong to the surrounding block. Detection is fully synchronous, so a pin level must be present at a rising clock edge to be seen.

Top module: `pin_change_irq`

## Requirements
- R1: With `det_mode` = 0 (any edge), 1 (rising) or 2 (falling), a matching change of an unmasked monitored pin between two consecutive clock samples sets `status_flag` at the clock edge that samples the new value.
- R2: With `det_mode` = 3 (low level), `status_flag` is set at every clock edge at which any unmasked monitored pin is 0. This holds regardless of earlier values.
- R3: `use_deb` = 0 monitors `raw_pins`, and `use_deb` = 1 monitors `deb_pins`. Activity on the unselected vector never sets the flag.
- R4: A pin whose `pin_mask` bit is 0 never sets the flag. Bit i of the mask belongs to bit i of both pin vectors.
- R5: `irq_out` is 1 exactly when `status_flag` is 1 and `irq_enable` is 1. `irq_enable` has no effect on how `status_flag` is set or cleared.
- R6: `status_flag` holds its value until a clock edge with `status_clear` = 1. It then clears, unless a set condition occurs at that same edge, in which case it stays 1.
- R7: No edge is detected in the cycle where `use_deb` differs from its value at the previous clock edge. No edge is detected in the first cycle after reset.
- R8: A pin change that lasts exactly one clock cycle is detected in edge modes.
- R9: While `rst_n` is 0, `status_flag` and `irq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_pins | input | NPINS | Synchronised raw pin samples |
| deb_pins | input | NPINS | Debounced pin samples |
| pin_mask | input | NPINS | Per-pin monitor enable, 1 = monitored |
| det_mode | input | 2 | 0 any edge, 1 rising, 2 falling, 3 low level |
| use_deb | input | 1 | Source select, 0 raw, 1 debounced |
| irq_enable | input | 1 | Gates the interrupt request |
| status_clear | input | 1 | One-cycle clear strobe for the flag |
| status_flag | output | 1 | Sticky event flag |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench switches the source select while the two vectors differ. A design that does not reload the previous-cycle copy would report a false edge there. It also releases reset with pins already high in rising mode, which catches a history register that starts at zero and fires on the first cycle. The bench asserts a clear in the same cycle as a set condition to show that the set wins. It holds a pin low while clearing in level mode, where a design that gives the clear priority would drop the interrupt. A one-cycle pin pulse, masked pins, and activity on the unselected vector check that the history compare, the mask and the source mux are each wired correctly.

// File: rtl/pcd_pkg.sv
// Package: shared types for the pin-change interrupt detector.
// Assumes the mode encoding is fixed by the register layout of the owner block.
package pcd_pkg;
    typedef enum logic [1:0] {
        DET_ANY  = 2'd0,
        DET_RISE = 2'd1,
        DET_FALL = 2'd2,
        DET_LOW  = 2'd3
    } det_mode_e;
endpackage

// File: rtl/pcd_source.sv
// Module: pcd_source
// Selects the monitored pin vector and keeps a one-cycle history of it.
// Assumes both inputs are already synchronous to clk.
// edge_ok is low in the first cycle after reset and in any cycle where
// the source select changed, so those cycles cannot report an edge.
module pcd_source #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] raw_pins,
    input  logic [NPINS-1:0] deb_pins,
    input  logic             use_deb,
    output logic [NPINS-1:0] cur_vec,
    output logic [NPINS-1:0] prev_vec,
    output logic             sel_q,
    output logic             edge_ok
);
    logic primed_q;

    // Source multiplexer.
    always_comb cur_vec = use_deb ? deb_pins : raw_pins;

    // History copy, registered select and a primed marker after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_vec <= '0;
            sel_q    <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            prev_vec <= cur_vec;
            sel_q    <= use_deb;
            primed_q <= 1'b1;
        end
    end

    // Edges are meaningful only when the history holds the same source.
    always_comb edge_ok = primed_q && (sel_q == use_deb);
endmodule

// File: rtl/pcd_match.sv
// Module: pcd_match
// Evaluates the detection condition per pin and reduces it to one hit.
// Purely combinational; assumes prev_vec holds the previous sample of cur_vec.
module pcd_match
    import pcd_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0] cur_vec,
    input  logic [NPINS-1:0] prev_vec,
    input  logic [NPINS-1:0] pin_mask,
    input  det_mode_e        mode,
    input  logic             edge_ok,
    output logic             hit
);
    logic [NPINS-1:0] pin_hit;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // Per-pin condition for the selected mode.
        always_comb begin
            unique case (mode)
                DET_ANY:  pin_hit[i] = edge_ok && (cur_vec[i] != prev_vec[i]);
                DET_RISE: pin_hit[i] = edge_ok && cur_vec[i] && !prev_vec[i];
                DET_FALL: pin_hit[i] = edge_ok && !cur_vec[i] && prev_vec[i];
                default:  pin_hit[i] = !cur_vec[i];
            endcase
        end
    end

    // Masked reduction to one event.
    always_comb hit = |(pin_hit & pin_mask);
endmodule

// File: rtl/pcd_flag.sv
// Module: pcd_flag
// Sticky status flag: set by hit, cleared by a strobe, set has priority.
module pcd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clear,
    output logic flag
);
    // Flag update with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (hit)   flag <= 1'b1;
        else if (clear) flag <= 1'b0;
    end
endmodule

// File: rtl/pin_change_irq.sv
// Module: pin_change_irq (top)
// Pin-change interrupt detector over NPINS synchronised pins.
// Assumes the pins are already synchronised and any debouncing is done upstream.
module pin_change_irq
    import pcd_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] raw_pins,
    input  logic [NPINS-1:0] deb_pins,
    input  logic [NPINS-1:0] pin_mask,
    input  logic [1:0]       det_mode,
    input  logic             use_deb,
    input  logic             irq_enable,
    input  logic             status_clear,
    output logic             status_flag,
    output logic             irq_out
);
    logic [NPINS-1:0] cur_vec;
    logic [NPINS-1:0] prev_vec;
    logic             src_sel_q;
    logic             edge_ok;
    logic             cond_hit;
    det_mode_e        mode;

    // Decode the mode field into the enum.
    always_comb mode = det_mode_e'(det_mode);

    pcd_source #(.NPINS(NPINS)) u_source (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_pins (raw_pins),
        .deb_pins (deb_pins),
        .use_deb  (use_deb),
        .cur_vec  (cur_vec),
        .prev_vec (prev_vec),
        .sel_q    (src_sel_q),
        .edge_ok  (edge_ok)
    );

    pcd_match #(.NPINS(NPINS)) u_match (
        .cur_vec  (cur_vec),
        .prev_vec (prev_vec),
        .pin_mask (pin_mask),
        .mode     (mode),
        .edge_ok  (edge_ok),
        .hit      (cond_hit)
    );

    pcd_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (cond_hit),
        .clear (status_clear),
        .flag  (status_flag)
    );

    // Request is the flag gated by the enable.
    always_comb irq_out = status_flag & irq_enable;
endmodule

// File: rtl/pcd_checker.sv
// Module: pcd_checker
// Assertion checker attached to pin_change_irq by bind.
module pcd_checker #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] pin_mask,
    input logic [1:0]       det_mode,
    input logic             use_deb,
    input logic             src_sel_q,
    input logic             irq_enable,
    input logic             status_clear,
    input logic             cond_hit,
    input logic             status_flag,
    input logic             irq_out
);
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_flag && !status_clear) |=> status_flag);

    // R6
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clear && !cond_hit) |=> !status_flag);

    // R4
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mask == '0 && !status_flag) |=> !status_flag);

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_enable || !status_flag) |-> !irq_out);

    // R7
    sel_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_deb != src_sel_q && det_mode != 2'd3 && !status_flag) |=> !status_flag);
endmodule

bind pin_change_irq pcd_checker #(.NPINS(NPINS)) u_pcd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_mask     (pin_mask),
    .det_mode     (det_mode),
    .use_deb      (use_deb),
    .src_sel_q    (src_sel_q),
    .irq_enable   (irq_enable),
    .status_clear (status_clear),
    .cond_hit     (cond_hit),
    .status_flag  (status_flag),
    .irq_out      (irq_out)
);

// File: tb/test_pin_change_irq.sv
// Bench for pin_change_irq: a vector table followed by directed corner tests.
module test_pin_change_irq;
    localparam int NPINS = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NPINS-1:0] raw_pins, deb_pins, pin_mask;
    logic [1:0]       det_mode;
    logic             use_deb, irq_enable, status_clear;
    logic             status_flag, irq_out;
    int               n_checks = 0;
    int               n_fail = 0;
    bit               done = 1'b0;

    always #2.5 clk = ~clk;

    pin_change_irq #(.NPINS(NPINS)) i_pin_change_irq (.*);

    typedef struct packed {
        logic [3:0] req;
        logic [1:0] mode;
        logic       sel;
        logic [7:0] mask;
        logic [7:0] raw_a;
        logic [7:0] raw_b;
        logic [7:0] deb_a;
        logic [7:0] deb_b;
        logic       exp;
    } vec_t;

    // Entries: req, mode, select, mask, raw before/after, deb before/after, expected flag.
    localparam vec_t TBL [0:11] = '{
        '{4'd1, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h00, 1'b1}, // R1 any, rise
        '{4'd1, 2'd0, 1'b0, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, 1'b1}, // R1 any, fall
        '{4'd1, 2'd1, 1'b0, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0}, // R1 rise mode ignores fall
        '{4'd4, 2'd1, 1'b0, 8'h0F, 8'h00, 8'h10, 8'h00, 8'h00, 1'b0}, // R4 masked pin
        '{4'd4, 2'd1, 1'b0, 8'h0F, 8'h00, 8'h04, 8'h00, 8'h00, 1'b1}, // R4 unmasked pin
        '{4'd1, 2'd2, 1'b0, 8'hFF, 8'h80, 8'h00, 8'h00, 8'h00, 1'b1}, // R1 fall mode
        '{4'd1, 2'd2, 1'b0, 8'hFF, 8'h00, 8'h80, 8'h00, 8'h00, 1'b0}, // R1 fall ignores rise
        '{4'd2, 2'd3, 1'b0, 8'h0F, 8'hFF, 8'hF7, 8'h00, 8'h00, 1'b1}, // R2 low on unmasked
        '{4'd2, 2'd3, 1'b0, 8'h0F, 8'hFF, 8'h0F, 8'h00, 8'h00, 1'b0}, // R2 low only on masked
        '{4'd3, 2'd0, 1'b1, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0}, // R3 raw ignored on deb
        '{4'd3, 2'd0, 1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h02, 1'b1}, // R3 deb watched
        '{4'd3, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b0}  // R3 deb ignored on raw
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R9 / R7: reset with pins high in rising mode, no event after release.
        rst_n = 1'b0; raw_pins = 8'hFF; deb_pins = 8'hFF; pin_mask = 8'hFF;
        det_mode = 2'd1; use_deb = 1'b0; irq_enable = 1'b1; status_clear = 1'b0;
        cycles(3);
        check("R9", "flag in reset", status_flag, 1'b0);
        check("R9", "irq in reset", irq_out, 1'b0);
        rst_n = 1'b1;
        cycles(2);
        check("R7", "no edge after reset", status_flag, 1'b0);

        // Table walk.
        for (int k = 0; k < 12; k++) begin
            det_mode = TBL[k].mode; use_deb = TBL[k].sel; pin_mask = TBL[k].mask;
            raw_pins = TBL[k].raw_a; deb_pins = TBL[k].deb_a; status_clear = 1'b1;
            cycles(2);
            status_clear = 1'b0;
            raw_pins = TBL[k].raw_b; deb_pins = TBL[k].deb_b;
            cycles(1);
            check($sformatf("R%0d", TBL[k].req), $sformatf("table entry %0d", k),
                  status_flag, TBL[k].exp);
        end

        // R5: disabled request, flag still sets, then enable.
        irq_enable = 1'b0; det_mode = 2'd0; use_deb = 1'b0; pin_mask = 8'hFF;
        raw_pins = 8'h00; status_clear = 1'b1;
        cycles(2);
        status_clear = 1'b0; raw_pins = 8'h20;
        cycles(1);
        check("R5", "flag with enable low", status_flag, 1'b1);
        check("R5", "irq with enable low", irq_out, 1'b0);
        irq_enable = 1'b1;
        #1;
        check("R5", "irq with enable high", irq_out, 1'b1);

        // R6: sticky, clear without event, set wins.
        cycles(3);
        check("R6", "flag sticky", status_flag, 1'b1);
        status_clear = 1'b1;
        cycles(1);
        status_clear = 1'b0;
        check("R6", "clear strobe", status_flag, 1'b0);
        status_clear = 1'b1; raw_pins = 8'h00;
        cycles(1);
        status_clear = 1'b0;
        check("R6", "set wins over clear", status_flag, 1'b1);

        // R2 / R6: level held low keeps flag through a clear.
        det_mode = 2'd3; raw_pins = 8'hFE; status_clear = 1'b1;
        cycles(2);
        check("R2", "low level stays set under clear", status_flag, 1'b1);
        status_clear = 1'b0;

        // R7: source switch with differing vectors causes no event.
        det_mode = 2'd0; raw_pins = 8'h00; deb_pins = 8'hFF; use_deb = 1'b0;
        status_clear = 1'b1;
        cycles(2);
        status_clear = 1'b0;
        use_deb = 1'b1;
        cycles(1);
        check("R7", "switch to deb", status_flag, 1'b0);
        use_deb = 1'b0;
        cycles(1);
        check("R7", "switch to raw", status_flag, 1'b0);

        // R8: one-cycle pulse in rising mode.
        det_mode = 2'd1;
        cycles(1);
        raw_pins = 8'h08;
        cycles(1);
        raw_pins = 8'h00;
        cycles(2);
        check("R8", "single-cycle pulse", status_flag, 1'b1);

        // R9: reset while flag set.
        rst_n = 1'b0;
        cycles(1);
        check("R9", "reset clears flag", status_flag, 1'b0);
        check("R9", "reset clears irq", irq_out, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule